// File: doc/BRIEF.md
# Block-Threshold Receive FIFO

This block is a circular receive store that sits between a bit-level frame receiver and a host controller. The receiver pushes one byte per write strobe and marks the end of each frame. The host does not pop bytes one at a time. It moves data in blocks, and it is the master of that transfer: the FIFO signals that a segment is ready, the host reads the segment at its own pace through a byte offset relative to the segment base, and then it issues a release command. That command frees the segment's storage and clears the pending indication.

Two kinds of segment are presented. A full segment has the block size chosen by a 2-bit selector: `MIN_BLK`, 2×, 4× or 8× `MIN_BLK`. A closing segment carries the tail of a frame that is shorter than one block, and its byte count is reported. The default parameters (64 bytes, 4..32-byte blocks) suit a signalling channel. `DEPTH=128, MIN_BLK=8` (8..64-byte blocks) suits a bearer channel. Only one frame is held at a time. After a frame ends, new bytes are refused until the host has released that frame's closing segment.

Top module: `rxblk_fifo`

## Requirements
- R1: After reset, `irq_pool`, `irq_end` and `ovf_flag` are 0 and `seg_len` is 0.
- R2: `blk_sel` value s selects a block size of `MIN_BLK << s`. With the defaults, 0/1/2/3 give 4/8/16/32 bytes. The selector is sampled on the clock edge that presents a segment.
- R3: While no segment is pending, if the unreleased byte count at a clock edge is at least the selected block size, that edge raises `irq_pool` and sets `seg_len` to the block size. Because a written byte is counted from its own edge onward, `irq_pool` rises one edge after the write that completes the block.
- R4: While no segment is pending, no full block is stored and the stored frame has ended, the clock edge raises `irq_end` and sets `seg_len` to the remaining byte count, which lies between 0 and one block minus 1. When nothing is pending, `seg_len` reads 0.
- R5: `rd_data` is the byte at offset `rd_off` from the current segment base, with bytes in the order they were written. It is combinational in `rd_off`.
- R6: Asserting `cmd_ack` while a segment is pending advances the base by `seg_len`, frees those bytes and drops the indication at that edge. A new segment can be presented one edge later at the earliest. `cmd_ack` with nothing pending has no effect.
- R7: A byte written while `DEPTH` bytes are unreleased is dropped and sets `ovf_flag`. The flag stays set until the host releases that frame's closing segment.
- R8: Between a frame end and the release of its closing segment, incoming bytes and frame ends are dropped. Any such byte drop makes `ovf_flag` read 1 once that closing segment is released, because the dropped bytes belong to the next frame.
- R9: `cmd_reset` empties the store, zeroes the pointers and clears both interrupts and the overflow flag at the next edge. It takes priority over a write or `cmd_ack` in the same cycle, and the write is dropped without setting the flag.
- R10: `irq_pool` and `irq_end` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_sel | input | SEL_W | Block size selector |
| wr_valid | input | 1 | Receiver byte strobe |
| wr_data | input | 8 | Received byte |
| wr_eof | input | 1 | Frame end marker; may come with or without a byte |
| cmd_ack | input | 1 | Host release of the pending segment |
| cmd_reset | input | 1 | Host command that empties the FIFO |
| rd_off | input | OFF_W | Byte offset within the pending segment |
| rd_data | output | 8 | Byte at segment base plus `rd_off` |
| irq_pool | output | 1 | Full block ready |
| irq_end | output | 1 | Closing segment of a frame ready |
| seg_len | output | LEN_W | Byte count of the pending segment |
| ovf_flag | output | 1 | Bytes of the current frame were lost |

## Verification
On every cycle, the assertions check that the two interrupt lines are mutually exclusive and that a full segment's length is a power of two no smaller than `MIN_BLK`. They also check that a closing segment is shorter than the largest block, that the fill count never exceeds the depth, that a pending segment holds steady until it is released, and that a release or reset drops the indication. Other properties depend on the data and on event order: byte order across pointer wrap, which bytes are dropped at full or during the post-frame hold, and when the overflow flag attaches to the next frame. These are shown only by the bench's scenarios, compared cycle by cycle against a queue-based model.

// File: rtl/rxbf_pkg.sv
package rxbf_pkg;
   typedef enum logic [1:0] {
      SEG_NONE = 2'd0,
      SEG_POOL = 2'd1,
      SEG_END  = 2'd2
   } seg_kind_t;
endpackage

// File: rtl/rxbf_blk_decode.sv
module rxbf_blk_decode #(
   parameter int MIN_BLK = 4,
   parameter int SEL_W   = 2,
   parameter int LEN_W   = 6
) (
   input  logic [SEL_W-1:0] sel,
   output logic [LEN_W-1:0] blk_len
);
   localparam int NSIZE = 1 << SEL_W;

   logic [LEN_W-1:0] size_tab [NSIZE];

   for (genvar g = 0; g < NSIZE; g++) begin : g_size
      assign size_tab[g] = LEN_W'(MIN_BLK << g);
   end

   assign blk_len = size_tab[sel];
endmodule

// File: rtl/rxbf_store.sv
module rxbf_store #(
   parameter int DEPTH = 64,
   parameter int OFF_W = 5,
   parameter int LEN_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             wr_en,
   input  logic [7:0]       wr_data,
   input  logic             adv_en,
   input  logic [LEN_W-1:0] adv_len,
   input  logic [OFF_W-1:0] rd_off,
   output logic [7:0]       rd_data
);
   localparam int AW = $clog2(DEPTH);

   logic [7:0]    mem [DEPTH];
   logic [AW-1:0] wptr_q;
   logic [AW-1:0] base_q;

   always_ff @(posedge clk) begin
      if (wr_en) mem[wptr_q] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q <= '0;
         base_q <= '0;
      end else if (clr) begin
         wptr_q <= '0;
         base_q <= '0;
      end else begin
         if (wr_en)  wptr_q <= wptr_q + AW'(1);
         if (adv_en) base_q <= base_q + AW'(adv_len);
      end
   end

   assign rd_data = mem[base_q + AW'(rd_off)];
endmodule

// File: rtl/rxbf_ctrl.sv
module rxbf_ctrl
   import rxbf_pkg::*;
#(
   parameter int DEPTH   = 64,
   parameter int MIN_BLK = 4,
   parameter int MAX_BLK = 32,
   parameter int LEN_W   = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LEN_W-1:0] blk_len,
   input  logic             wr_valid,
   input  logic             wr_eof,
   input  logic             cmd_ack,
   input  logic             cmd_reset,
   output logic             wr_en,
   output logic             adv_en,
   output logic [LEN_W-1:0] adv_len,
   output logic             irq_pool,
   output logic             irq_end,
   output logic [LEN_W-1:0] seg_len,
   output logic             ovf_flag
);
   localparam int FW = $clog2(DEPTH + 1);

   seg_kind_t        kind_q;
   logic [FW-1:0]    fill_q;
   logic [LEN_W-1:0] len_q;
   logic             eof_q;
   logic             ovf_q;
   logic             hdrop_q;

   logic full, drop_full, drop_hold, end_ack;

   assign full      = (fill_q == FW'(DEPTH));
   assign wr_en     = !cmd_reset && wr_valid && !eof_q && !full;
   assign drop_full = !cmd_reset && wr_valid && !eof_q && full;
   assign drop_hold = !cmd_reset && wr_valid && eof_q;
   assign adv_en    = !cmd_reset && cmd_ack && (kind_q != SEG_NONE);
   assign adv_len   = len_q;
   assign end_ack   = adv_en && (kind_q == SEG_END);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q  <= SEG_NONE;
         fill_q  <= '0;
         len_q   <= '0;
         eof_q   <= 1'b0;
         ovf_q   <= 1'b0;
         hdrop_q <= 1'b0;
      end else if (cmd_reset) begin
         kind_q  <= SEG_NONE;
         fill_q  <= '0;
         len_q   <= '0;
         eof_q   <= 1'b0;
         ovf_q   <= 1'b0;
         hdrop_q <= 1'b0;
      end else begin
         fill_q <= fill_q + FW'(wr_en) - (adv_en ? FW'(len_q) : FW'(0));
         if (kind_q != SEG_NONE) begin
            if (adv_en) kind_q <= SEG_NONE;
         end else if (fill_q >= FW'(blk_len)) begin
            kind_q <= SEG_POOL;
            len_q  <= blk_len;
         end else if (eof_q) begin
            kind_q <= SEG_END;
            len_q  <= LEN_W'(fill_q);
         end
         eof_q   <= end_ack ? 1'b0 : (eof_q | wr_eof);
         ovf_q   <= end_ack ? (hdrop_q | drop_hold) : (ovf_q | drop_full);
         hdrop_q <= end_ack ? 1'b0 : (hdrop_q | drop_hold);
      end
   end

   assign irq_pool = (kind_q == SEG_POOL);
   assign irq_end  = (kind_q == SEG_END);
   assign seg_len  = (kind_q == SEG_NONE) ? '0 : len_q;
   assign ovf_flag = ovf_q;

   a_r10_irq_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(irq_pool && irq_end));

   a_r3_pool_len_shape: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pool |-> ($countones(seg_len) == 1 && seg_len >= LEN_W'(MIN_BLK)));

   a_r4_end_len_short: assert property (@(posedge clk) disable iff (!rst_n)
      irq_end |-> (seg_len < LEN_W'(MAX_BLK)));

   a_r6_ack_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_ack && (irq_pool || irq_end)) |=> !(irq_pool || irq_end));

   a_r6_pending_holds: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq_pool || irq_end) && !cmd_ack && !cmd_reset)
         |=> ($stable(seg_len) && $stable(irq_pool) && $stable(irq_end)));

   a_r7_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
      fill_q <= FW'(DEPTH));

   a_r9_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_reset |=> (fill_q == '0 && !irq_pool && !irq_end && !ovf_flag));
endmodule

// File: rtl/rxblk_fifo.sv
module rxblk_fifo #(
   parameter int DEPTH   = 64,
   parameter int MIN_BLK = 4,
   parameter int SEL_W   = 2,
   localparam int MAX_BLK = MIN_BLK << ((1 << SEL_W) - 1),
   localparam int OFF_W   = $clog2(MAX_BLK),
   localparam int LEN_W   = $clog2(MAX_BLK + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] blk_sel,
   input  logic             wr_valid,
   input  logic [7:0]       wr_data,
   input  logic             wr_eof,
   input  logic             cmd_ack,
   input  logic             cmd_reset,
   input  logic [OFF_W-1:0] rd_off,
   output logic [7:0]       rd_data,
   output logic             irq_pool,
   output logic             irq_end,
   output logic [LEN_W-1:0] seg_len,
   output logic             ovf_flag
);
   if ((DEPTH & (DEPTH - 1)) != 0) begin : g_chk_depth
      $error("rxblk_fifo: DEPTH must be a power of two");
   end
   if (MIN_BLK < 1 || (MIN_BLK & (MIN_BLK - 1)) != 0) begin : g_chk_min
      $error("rxblk_fifo: MIN_BLK must be a power of two");
   end
   if (MAX_BLK > DEPTH) begin : g_chk_max
      $error("rxblk_fifo: largest block exceeds DEPTH");
   end

   logic [LEN_W-1:0] blk_len;
   logic             wr_en;
   logic             adv_en;
   logic [LEN_W-1:0] adv_len;

   rxbf_blk_decode #(
      .MIN_BLK (MIN_BLK),
      .SEL_W   (SEL_W),
      .LEN_W   (LEN_W)
   ) decode_i (
      .sel     (blk_sel),
      .blk_len (blk_len)
   );

   rxbf_ctrl #(
      .DEPTH   (DEPTH),
      .MIN_BLK (MIN_BLK),
      .MAX_BLK (MAX_BLK),
      .LEN_W   (LEN_W)
   ) ctrl_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .blk_len   (blk_len),
      .wr_valid  (wr_valid),
      .wr_eof    (wr_eof),
      .cmd_ack   (cmd_ack),
      .cmd_reset (cmd_reset),
      .wr_en     (wr_en),
      .adv_en    (adv_en),
      .adv_len   (adv_len),
      .irq_pool  (irq_pool),
      .irq_end   (irq_end),
      .seg_len   (seg_len),
      .ovf_flag  (ovf_flag)
   );

   rxbf_store #(
      .DEPTH (DEPTH),
      .OFF_W (OFF_W),
      .LEN_W (LEN_W)
   ) store_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (cmd_reset),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .adv_en  (adv_en),
      .adv_len (adv_len),
      .rd_off  (rd_off),
      .rd_data (rd_data)
   );
endmodule

// File: tb/rxblk_fifo_tb_top.sv
module rxblk_fifo_tb_top;
   localparam int DEPTH   = 64;
   localparam int MIN_BLK = 4;
   localparam int SEL_W   = 2;
   localparam int MAX_BLK = MIN_BLK << ((1 << SEL_W) - 1);
   localparam int OFF_W   = $clog2(MAX_BLK);
   localparam int LEN_W   = $clog2(MAX_BLK + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [SEL_W-1:0] blk_sel = '0;
   logic wr_valid = 1'b0;
   logic [7:0] wr_data = '0;
   logic wr_eof = 1'b0;
   logic cmd_ack = 1'b0;
   logic cmd_reset = 1'b0;
   logic [OFF_W-1:0] rd_off = '0;
   logic [7:0] rd_data;
   logic irq_pool, irq_end, ovf_flag;
   logic [LEN_W-1:0] seg_len;

   always #5 clk = ~clk;

   rxblk_fifo #(.DEPTH(DEPTH), .MIN_BLK(MIN_BLK), .SEL_W(SEL_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .blk_sel(blk_sel), .wr_valid(wr_valid),
      .wr_data(wr_data), .wr_eof(wr_eof), .cmd_ack(cmd_ack),
      .cmd_reset(cmd_reset), .rd_off(rd_off), .rd_data(rd_data),
      .irq_pool(irq_pool), .irq_end(irq_end), .seg_len(seg_len),
      .ovf_flag(ovf_flag)
   );

   int nchk = 0;
   int nfail = 0;
   bit done = 1'b0;

   // reference model state
   byte unsigned mq[$];
   int m_kind = 0;   // 0 none, 1 full block, 2 frame tail
   int m_len = 0;
   bit m_eof = 0, m_ovf = 0, m_hd = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_update();
      int sz, blk, olen;
      bit acc, fd, hd, adv, endack;
      if (!rst_n || cmd_reset) begin
         mq.delete();
         m_kind = 0; m_len = 0; m_eof = 0; m_ovf = 0; m_hd = 0;
         return;
      end
      sz = mq.size();
      blk = MIN_BLK << blk_sel;
      olen = m_len;
      acc = wr_valid && !m_eof && sz < DEPTH;
      fd = wr_valid && !m_eof && sz == DEPTH;
      hd = wr_valid && m_eof;
      adv = cmd_ack && m_kind != 0;
      endack = adv && m_kind == 2;
      if (m_kind != 0) begin
         if (adv) m_kind = 0;
      end else if (sz >= blk) begin
         m_kind = 1; m_len = blk;
      end else if (m_eof) begin
         m_kind = 2; m_len = sz;
      end
      if (adv) for (int i = 0; i < olen; i++) void'(mq.pop_front());
      if (acc) mq.push_back(wr_data);
      if (endack) begin
         m_ovf = m_hd | hd; m_hd = 0; m_eof = 0;
      end else begin
         m_ovf = m_ovf | fd; m_hd = m_hd | hd; m_eof = m_eof | wr_eof;
      end
   endtask

   task automatic compare();
      int ep, ee, el;
      ep = (m_kind == 1); ee = (m_kind == 2); el = (m_kind != 0) ? m_len : 0;
      chk(irq_pool == ep, "R3 irq_pool", irq_pool, ep);
      chk(irq_end == ee, "R4 irq_end", irq_end, ee);
      chk(seg_len == el, "R4 seg_len", seg_len, el);
      chk(ovf_flag == m_ovf, "R7 ovf_flag", ovf_flag, m_ovf);
      chk(!(irq_pool && irq_end), "R10 exclusive", irq_pool & irq_end, 0);
      if (rd_off < mq.size())
         chk(rd_data == mq[rd_off], "R5 rd_data", rd_data, mq[rd_off]);
   endtask

   // one clock: inputs are already driven; model and compare
   task automatic cyc();
      @(posedge clk);
      model_update();
      @(negedge clk);
      compare();
      wr_valid = 0; wr_eof = 0; cmd_ack = 0; cmd_reset = 0;
   endtask

   task automatic wr(input byte unsigned d, input bit e);
      wr_valid = 1; wr_data = d; wr_eof = e;
      cyc();
   endtask

   task automatic ack();
      cmd_ack = 1;
      cyc();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nchk++; nfail++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("[TB] %0d tests run, %0d failed", nchk, nfail);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      cyc();
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(irq_pool == 0 && irq_end == 0, "R1 irqs", {irq_pool, irq_end}, 0);
      chk(seg_len == 0, "R1 seg_len", seg_len, 0);
      chk(ovf_flag == 0, "R1 ovf", ovf_flag, 0);

      // R2/R3/R4: each block size, then empty tail
      for (int s = 0; s < 4; s++) begin
         blk_sel = SEL_W'(s);
         for (int i = 0; i < (MIN_BLK << s); i++) wr(byte'(s * 40 + i), 0);
         chk(irq_pool == 0, "R3 not before next edge", irq_pool, 0);
         cyc();
         chk(irq_pool == 1, "R3 pool raised", irq_pool, 1);
         chk(seg_len == (MIN_BLK << s), "R2 block size", seg_len, MIN_BLK << s);
         ack();
         chk(irq_pool == 0, "R6 ack clears", irq_pool, 0);
         wr_eof = 1; cyc();
         cyc();
         chk(irq_end == 1 && seg_len == 0, "R4 empty tail", seg_len, 0);
         ack();
      end

      // R4 tail length, sel 1 (8 bytes)
      blk_sel = 1;
      for (int i = 0; i < 19; i++) wr(byte'(100 + i), i == 18);
      cyc();
      chk(irq_pool == 1 && seg_len == 8, "R2 first block", seg_len, 8);
      rd_off = 3; cyc();
      chk(rd_data == 103, "R5 offset read", rd_data, 103);
      ack(); cyc();
      chk(irq_pool == 1 && rd_data == 111, "R5 second block", rd_data, 111);
      ack(); cyc();
      chk(irq_end == 1 && seg_len == 3, "R4 tail count", seg_len, 3);
      rd_off = 2; cyc();
      chk(rd_data == 118, "R5 tail byte", rd_data, 118);
      ack(); cyc();
      chk(irq_pool == 0 && irq_end == 0, "R6 frame released", irq_end, 0);
      rd_off = 0;

      // R6 ack with nothing pending
      ack();
      blk_sel = 0;
      for (int i = 0; i < 4; i++) wr(byte'(200 + i), 0);
      cyc();
      chk(irq_pool == 1 && rd_data == 200, "R6 idle ack ignored", rd_data, 200);
      ack();
      for (int i = 0; i < 3; i++) cyc();
      chk(irq_pool == 0, "R6 no spurious block", irq_pool, 0);
      wr_eof = 1; cyc(); cyc(); ack();

      // R7 overflow at full
      blk_sel = 3;
      for (int i = 0; i < 70; i++) wr(byte'(i), 0);
      chk(ovf_flag == 1, "R7 overflow set", ovf_flag, 1);
      ack();
      wr_eof = 1; cyc();
      chk(irq_pool == 1 && rd_data == 32, "R7 kept bytes", rd_data, 32);
      ack(); cyc();
      chk(irq_end == 1 && ovf_flag == 1, "R7 flag held to tail", ovf_flag, 1);
      ack();
      chk(ovf_flag == 0, "R7 flag cleared on tail release", ovf_flag, 0);

      // R8 hold after frame end
      blk_sel = 0;
      for (int i = 0; i < 5; i++) wr(byte'(50 + i), i == 4);
      for (int i = 0; i < 3; i++) wr(byte'(90 + i), 0);
      chk(ovf_flag == 0, "R8 prior frame clean", ovf_flag, 0);
      ack(); cyc();
      chk(irq_end == 1 && seg_len == 1 && rd_data == 54, "R8 tail intact", rd_data, 54);
      ack();
      chk(ovf_flag == 1, "R8 flag moves to next frame", ovf_flag, 1);
      wr(8'h33, 0); wr(8'h44, 1); cyc();
      chk(irq_end == 1 && seg_len == 2, "R8 next frame accepted", seg_len, 2);
      ack();
      chk(ovf_flag == 0, "R8 flag cleared", ovf_flag, 0);

      // R9 reset command
      for (int i = 0; i < 6; i++) wr(byte'(i), 0);
      cmd_reset = 1; wr_valid = 1; wr_data = 8'hEE; cmd_ack = 1; cyc();
      chk(irq_pool == 0 && irq_end == 0 && ovf_flag == 0, "R9 cleared", irq_pool, 0);
      for (int i = 0; i < 3; i++) cyc();
      chk(irq_pool == 0, "R9 empty", irq_pool, 0);
      for (int i = 0; i < 4; i++) wr(byte'(70 + i), 0);
      cyc();
      chk(irq_pool == 1 && rd_data == 70, "R9 pointers zeroed", rd_data, 70);
      ack();

      // mixed traffic against the model
      for (int n = 0; n < 6000; n++) begin
         wr_valid = ($urandom % 3) != 0;
         wr_data = 8'($urandom);
         wr_eof = ($urandom % 20) == 0;
         cmd_ack = (irq_pool || irq_end) && (($urandom % 3) == 0);
         cmd_reset = ($urandom % 900) == 0;
         rd_off = OFF_W'($urandom);
         if (($urandom % 200) == 0) blk_sel = SEL_W'($urandom);
         cyc();
      end

      done = 1;
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
   end
endmodule